// File: doc/BRIEF.md
# Shared Multi-Hart Timer with Memory-Mapped Compare Registers

This block keeps a single 64-bit real-time counter that several harts share, plus one 64-bit compare register for each hart. A simple request/response bus reaches all of these registers through a flat byte-addressed window. The counter sits in the first 8-byte slot. The compare register for hart i sits in the 8-byte slot at byte offset 8*(1+i). The counter moves forward only through a tick input, which carries its own increment amount. The bus can read the counter but cannot write it.

Each hart gets a level-sensitive timer-pending output. The output is high while the counter is greater than or equal to that hart's compare value, using an unsigned comparison. It is recomputed from the current register contents and is not latched. Software clears a pending interrupt by writing a larger compare value. Software raises one by letting time pass the compare value or by writing a smaller compare value.

Every bus request gets exactly one response on the following cycle. The response carries read data and an error flag. A request that is out of range, misshaped or forbidden is answered with an error and changes nothing.

Top module: `hart_timer`

## Requirements
- R1: After reset the counter reads 0, every compare register reads all ones (0xFFFF_FFFF_FFFF_FFFF), every timerPending bit is 0 and rspValid is 0.
- R2: On a cycle with tickValid high, the counter becomes counter + tickInc. On a cycle with tickValid low, the counter keeps its value.
- R3: A request with reqValid high in cycle t produces rspValid high in cycle t+1. rspValid is low in any cycle that does not follow a request. rspErr is meaningful only when rspValid is high.
- R4: A load reads reqLen bytes starting at reqAddr from the register image, where each register is stored little-endian: byte k of slot s is bits [8k+7:8k] of that register. The first byte appears in rspRdata[7:0]. The upper bytes of rspRdata that were not requested are 0. The counter slot (bytes 0..7) is readable.
- R5: A request with any of the following is answered with rspErr=1 and rspRdata=0 and changes no register:
  - reqLen equal to 0 or greater than 8;
  - reqAddr+reqLen greater than 8*(1+NUM_HARTS);
  - (reqAddr mod 8)+reqLen greater than 8, meaning it crosses an 8-byte slot.
- R6: A store with reqAddr below 8 is answered with rspErr=1 and leaves the counter unchanged.
- R7: A legal store writes the low reqLen bytes of reqWdata into bytes (reqAddr mod 8) onward of compare register (reqAddr/8 - 1). All other bytes keep their values. The response has rspErr=0 and rspRdata=0.
- R8: timerPending[h] is 1 exactly when counter >= compare[h] as unsigned 64-bit values. It reflects the register values from the same cycle in which a tick or a store takes effect.
- R9: Writing a compare value larger than the counter drops that hart's pending bit, and no tick is needed for the drop.
- R10: When a legal store and a tick occur in the same cycle, both take effect. The pending bits then reflect the advanced counter and the newly written compare value together.
- R11: The counter wraps modulo 2^64. After a wrap, pending is again a plain unsigned compare against the wrapped value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Bus request present this cycle |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqAddr | input | ADDR_W | Byte address inside the window |
| reqLen | input | 4 | Access length in bytes (legal 1..8) |
| reqWdata | input | 64 | Store data, least significant byte first |
| tickValid | input | 1 | Advance the counter this cycle |
| tickInc | input | INC_W | Amount added to the counter on a tick |
| rspValid | output | 1 | Response present (one cycle after a request) |
| rspErr | output | 1 | Request rejected |
| rspRdata | output | 64 | Load data, least significant byte first |
| timerPending | output | NUM_HARTS | Per-hart timer interrupt pending level |

## Verification
The assertions assume three things about the inputs:
- reqValid is a single-cycle strobe that the block samples at each rising edge.
- reqAddr, reqLen and reqWrite are known whenever reqValid is high.
- tickValid is never unknown after reset.

The stimulus keeps within these assumptions. It changes every input only at the falling clock edge and drops reqValid after one cycle. It keeps tickValid at a defined value throughout, including during reset. Error cases are limited to address, length and write-protection violations that the block itself must detect. The same-cycle tick-plus-store case and the counter wrap are driven directly rather than left to chance.

// File: rtl/hart_timer_pkg.sv
package hart_timer_pkg;
  // Width of the slot index carried from control to datapath (up to 255 harts).
  localparam int IDX_W = 8;

  // Strobes from control to datapath for one accepted access.
  typedef struct packed {
    logic             rdEn;
    logic             wrEn;
    logic [IDX_W-1:0] regIdx;
    logic [2:0]       byteOff;
    logic [3:0]       byteLen;
  } strobe_t;
endpackage

// File: rtl/hart_timer_ctrl.sv
module hart_timer_ctrl
  import hart_timer_pkg::*;
#(
  parameter int NUM_HARTS = 2,
  parameter int ADDR_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [3:0]        reqLen,
  output strobe_t           stb,
  output logic              rspValid,
  output logic              rspErr
);
  localparam int WIN_BYTES = 8 * (1 + NUM_HARTS);
  localparam logic [ADDR_W:0]   WIN_END   = (ADDR_W+1)'(WIN_BYTES);
  localparam logic [ADDR_W-1:0] FIRST_CMP = ADDR_W'(8);

  logic [ADDR_W:0] endAddr;
  logic [4:0]      slotEnd;
  logic            lenOk, inWin, noCross, wrAllowed, accOk;

  always_comb begin
    endAddr   = {1'b0, reqAddr} + (ADDR_W+1)'(reqLen);
    slotEnd   = 5'(reqAddr[2:0]) + 5'(reqLen);
    lenOk     = (reqLen != 4'd0) && (reqLen <= 4'd8);
    inWin     = endAddr <= WIN_END;
    noCross   = slotEnd <= 5'd8;
    wrAllowed = !reqWrite || (reqAddr >= FIRST_CMP);
    accOk     = reqValid && lenOk && inWin && noCross && wrAllowed;

    stb.rdEn    = accOk && !reqWrite;
    stb.wrEn    = accOk && reqWrite;
    stb.regIdx  = IDX_W'(reqAddr >> 3);
    stb.byteOff = reqAddr[2:0];
    stb.byteLen = reqLen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
    end else begin
      rspValid <= reqValid;
      rspErr   <= reqValid && !accOk;
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R3
  AST_NO_RSP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid); // R3
  AST_LOW_STORE_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqAddr < FIRST_CMP) |=> (rspValid && rspErr)); // R6
  AST_ZERO_LEN_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqLen == 4'd0) |=> rspErr); // R5
endmodule

// File: rtl/hart_timer_dp.sv
module hart_timer_dp
  import hart_timer_pkg::*;
#(
  parameter int NUM_HARTS = 2,
  parameter int INC_W     = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [63:0]          reqWdata,
  input  logic                 tickValid,
  input  logic [INC_W-1:0]     tickInc,
  output logic [63:0]          rspRdata,
  output logic [NUM_HARTS-1:0] timerPending
);
  logic [63:0] timeQ;
  logic [63:0] cmpQ [NUM_HARTS];
  logic [15:0] lenMask;
  logic [7:0]  wrMask;
  logic [63:0] wrData;
  logic [63:0] selReg, rdShift, rdMask;

  // Counter: only a tick changes it, never the bus.
  always_ff @(posedge clk) begin
    if (!rstN)          timeQ <= '0;
    else if (tickValid) timeQ <= timeQ + 64'(tickInc);
  end

  // Byte-lane alignment for stores.
  always_comb begin
    lenMask = (16'd1 << stb.byteLen) - 16'd1;
    wrMask  = 8'(lenMask) << stb.byteOff;
    wrData  = reqWdata << {stb.byteOff, 3'b000};
  end

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmpQ[h] <= '1;
      end else if (stb.wrEn && stb.regIdx == IDX_W'(h + 1)) begin
        for (int b = 0; b < 8; b++)
          if (wrMask[b]) cmpQ[h][b*8 +: 8] <= wrData[b*8 +: 8];
      end
    end

    assign timerPending[h] = timeQ >= cmpQ[h];

    AST_CMP_HELD_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
      !stb.wrEn |=> $stable(cmpQ[h])); // R5
  end

  // Load path: pick the slot, align to byte 0, keep requested bytes.
  always_comb begin
    selReg = timeQ;
    for (int h = 0; h < NUM_HARTS; h++)
      if (stb.regIdx == IDX_W'(h + 1)) selReg = cmpQ[h];
    rdShift = selReg >> {stb.byteOff, 3'b000};
    for (int b = 0; b < 8; b++)
      rdMask[b*8 +: 8] = (4'(b) < stb.byteLen) ? 8'hFF : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         rspRdata <= '0;
    else if (stb.rdEn) rspRdata <= rdShift & rdMask;
    else               rspRdata <= '0;
  end

  AST_TIME_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !tickValid |=> $stable(timeQ)); // R2
  AST_RDATA_ZERO_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdEn |=> rspRdata == 64'd0); // R7
endmodule

// File: rtl/hart_timer.sv
module hart_timer
  import hart_timer_pkg::*;
#(
  parameter int NUM_HARTS = 2,
  parameter int ADDR_W    = 16,
  parameter int INC_W     = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [3:0]           reqLen,
  input  logic [63:0]          reqWdata,
  input  logic                 tickValid,
  input  logic [INC_W-1:0]     tickInc,
  output logic                 rspValid,
  output logic                 rspErr,
  output logic [63:0]          rspRdata,
  output logic [NUM_HARTS-1:0] timerPending
);
  strobe_t stb;

  hart_timer_ctrl #(.NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqLen(reqLen), .stb(stb),
    .rspValid(rspValid), .rspErr(rspErr)
  );

  hart_timer_dp #(.NUM_HARTS(NUM_HARTS), .INC_W(INC_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqWdata(reqWdata),
    .tickValid(tickValid), .tickInc(tickInc),
    .rspRdata(rspRdata), .timerPending(timerPending)
  );

  AST_ERR_HAS_NO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (rspValid && rspRdata == 64'd0)); // R5
endmodule

// File: tb/sim_hart_timer.sv
module sim_hart_timer;
  localparam int NH = 2;
  localparam int AW = 16;
  localparam int IW = 64;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [3:0]    reqLen = '0;
  logic [63:0]   reqWdata = '0;
  logic          tickValid = 1'b0;
  logic [IW-1:0] tickInc = '0;
  logic          rspValid, rspErr;
  logic [63:0]   rspRdata;
  logic [NH-1:0] timerPending;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  hart_timer #(.NUM_HARTS(NH), .ADDR_W(AW), .INC_W(IW)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqWdata(reqWdata),
    .tickValid(tickValid), .tickInc(tickInc),
    .rspValid(rspValid), .rspErr(rspErr), .rspRdata(rspRdata),
    .timerPending(timerPending)
  );

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [3:0]  len;
    logic [63:0] wdata;
    logic        err;
    logic [63:0] rdata;
  } vec_t;

  // Window is 24 bytes: counter at 0, compare0 at 8, compare1 at 16.
  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 16'd0,  4'd8, 64'h0, 1'b0, 64'h0},                   // R1 R4 counter reads 0
    '{1'b0, 16'd8,  4'd8, 64'h0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF}, // R1 compare resets to ones
    '{1'b1, 16'd8,  4'd8, 64'h1122_3344_5566_7788, 1'b0, 64'h0}, // R7 full store
    '{1'b0, 16'd8,  4'd8, 64'h0, 1'b0, 64'h1122_3344_5566_7788}, // R4
    '{1'b0, 16'd9,  4'd2, 64'h0, 1'b0, 64'h6677},                // R4 little-endian subrange
    '{1'b1, 16'd18, 4'd2, 64'hABCD, 1'b0, 64'h0},                // R7 partial store
    '{1'b0, 16'd16, 4'd8, 64'h0, 1'b0, 64'hFFFF_FFFF_ABCD_FFFF}, // R7 other bytes kept
    '{1'b1, 16'd0,  4'd8, 64'hDEAD, 1'b1, 64'h0},                // R6
    '{1'b1, 16'd4,  4'd2, 64'hBEEF, 1'b1, 64'h0},                // R6
    '{1'b0, 16'd20, 4'd8, 64'h0, 1'b1, 64'h0},                   // R5 crosses slot/window
    '{1'b0, 16'd24, 4'd1, 64'h0, 1'b1, 64'h0},                   // R5 past window
    '{1'b0, 16'd16, 4'd0, 64'h0, 1'b1, 64'h0},                   // R5 zero length
    '{1'b0, 16'd0,  4'd9, 64'h0, 1'b1, 64'h0},                   // R5 too long
    '{1'b1, 16'd22, 4'd4, 64'h0, 1'b1, 64'h0},                   // R5 crossing store
    '{1'b0, 16'd16, 4'd8, 64'h0, 1'b0, 64'hFFFF_FFFF_ABCD_FFFF}, // R5 no side effect
    '{1'b1, 16'd15, 4'd1, 64'h5A, 1'b0, 64'h0},                  // R7 top byte
    '{1'b0, 16'd8,  4'd8, 64'h0, 1'b0, 64'h5A22_3344_5566_7788}, // R7
    '{1'b0, 16'd0,  4'd8, 64'h0, 1'b0, 64'h0},                   // R6 counter untouched
    '{1'b0, 16'd23, 4'd1, 64'h0, 1'b0, 64'hFF}                   // R4 last legal byte
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%016h expected 0x%016h", tag, act, exp);
    end
  endtask

  // One request (optionally with a tick); returns the response seen one cycle later.
  task automatic access(input logic wr, input logic [15:0] addr, input logic [3:0] len,
                        input logic [63:0] wd, input logic tk, input logic [63:0] inc,
                        output logic ok, output logic err, output logic [63:0] rd);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqLen = len; reqWdata = wd;
    tickValid = tk; tickInc = inc;
    @(negedge clk);
    reqValid = 1'b0; tickValid = 1'b0;
    ok = rspValid; err = rspErr; rd = rspRdata;
  endtask

  task automatic tick(input logic [63:0] inc);
    @(negedge clk);
    tickValid = 1'b1; tickInc = inc;
    @(negedge clk);
    tickValid = 1'b0;
  endtask

  task automatic readTime(input string tag, input logic [63:0] exp);
    logic ok, err;
    logic [63:0] rd;
    access(1'b0, 16'd0, 4'd8, 64'h0, 1'b0, 64'h0, ok, err, rd);
    chk(tag, rd, exp);
  endtask

  task automatic store8(input logic [15:0] addr, input logic [63:0] v);
    logic ok, err;
    logic [63:0] rd;
    access(1'b1, addr, 4'd8, v, 1'b0, 64'h0, ok, err, rd);
    chk("R7 store accepted", {63'd0, err}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic ok, err;
    logic [63:0] rd;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 pending after reset", 64'(timerPending), 64'd0);
    chk("R1 R3 rspValid idle", {63'd0, rspValid}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].wr, VEC[i].addr, VEC[i].len, VEC[i].wdata, 1'b0, 64'h0, ok, err, rd);
      chk($sformatf("R3 table[%0d] rspValid", i), {63'd0, ok}, 64'd1);
      chk($sformatf("R5 table[%0d] rspErr", i), {63'd0, err}, {63'd0, VEC[i].err});
      chk($sformatf("R4 table[%0d] rspRdata", i), rd, VEC[i].rdata);
      chk($sformatf("R8 table[%0d] pending", i), 64'(timerPending), 64'd0);
    end
    @(negedge clk);
    chk("R3 no response without request", {63'd0, rspValid}, 64'd0);

    // Tick and compare behaviour
    store8(16'd8, 64'd100);
    store8(16'd16, 64'd200);
    tick(64'd50);
    chk("R8 below both compares", 64'(timerPending), 64'd0);
    readTime("R2 counter after tick", 64'd50);
    repeat (3) @(negedge clk);
    readTime("R2 counter holds without tick", 64'd50);
    tick(64'd50);
    chk("R8 equal compare hart0", 64'(timerPending), 64'b01);
    tick(64'd150);
    chk("R8 both pending", 64'(timerPending), 64'b11);
    store8(16'd8, 64'd1000);
    chk("R9 larger compare clears hart0", 64'(timerPending), 64'b10);

    // Store and tick in the same cycle
    access(1'b1, 16'd16, 4'd8, 64'd1001, 1'b1, 64'd750, ok, err, rd);
    chk("R10 store accepted with tick", {63'd0, err}, 64'd0);
    chk("R10 pending uses new time and compare", 64'(timerPending), 64'b01);
    readTime("R10 counter advanced", 64'd1000);

    // Wrap past 2^64
    tick(64'hFFFF_FFFF_FFFF_FC1D);  // 1000 + this = 2^64 + 5
    readTime("R11 counter wrapped", 64'd5);
    chk("R11 no pending after wrap", 64'(timerPending), 64'd0);
    store8(16'd16, 64'd3);
    chk("R11 plain compare after wrap", 64'(timerPending), 64'b10);
    access(1'b1, 16'd0, 4'd8, 64'd0, 1'b0, 64'h0, ok, err, rd);
    chk("R6 store to counter rejected", {63'd0, err}, 64'd1);
    readTime("R6 counter unchanged", 64'd5);

    // Reset in mid-run
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    chk("R1 pending cleared by reset", 64'(timerPending), 64'd0);
    readTime("R1 counter cleared by reset", 64'd0);
    access(1'b0, 16'd16, 4'd8, 64'h0, 1'b0, 64'h0, ok, err, rd);
    chk("R1 compare back to ones", rd, 64'hFFFF_FFFF_FFFF_FFFF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule